// File: doc/BRIEF.md
# Idle-Pair Rate Match FIFO

This block is the elastic store that sits between the recovered receive clock and the local reference clock of a 1000BASE-X receive lane. It carries decoded symbols, each an 8-bit value with a control flag. It absorbs the frequency offset between the two clocks, up to 200 ppm in total. It does this by dropping or replaying complete I2 idle sets, where an I2 set is a K28.5 control symbol immediately followed by a D16.2 data symbol. It never adds or removes a single symbol on its own.

The write side stages one symbol so that it can recognise an I2 pair before any part of it is stored. It drops the whole pair when the fill level it sees is above a high threshold. The read side starts reading once the store reaches a nominal fill. After it has read a genuine I2 pair, it replays one more I2 pair without advancing its pointer if the fill level it sees is at or below a low threshold. Pointers cross between the clocks in gray code through two-flop synchronisers. While the lane reports no sync, the block passes symbols straight through and does no correction.

Top module: `rmf_top`

## Requirements
- R1: While either reset is high and in the first cycles after it, rd_valid, rd_inserted and wr_deleted are low.
- R2: While sync_ok is low, the read stream equals the written stream symbol for symbol, and neither flag rises.
- R3: With sync_ok high and the write-side fill above HI_MARK, a control symbol 0xBC directly followed by data symbol 0x50 is dropped as one pair. wr_deleted is high for exactly one write cycle, the cycle after the 0x50 was taken.
- R4: With sync_ok high, after the read side outputs a genuine 0xBC (control) then 0x50 (data) while its fill is at or below LO_MARK, it outputs one extra 0xBC (control) and then 0x50 (data), with rd_inserted high on both cycles.
- R5: Only I2 pairs are ever dropped or replayed. A C1 pair (control 0xBC then data 0xB5) and packet data are never dropped or duplicated, and a stream of C1 pairs alone causes no insertion.
- R6: Apart from whole dropped or replayed I2 pairs, the order and value of every symbol is preserved.
- R7: With sync_ok high and a read clock 2 % slower or faster than the write clock, the store neither overflows nor corrupts data, given idle pairs in every gap between packets.
- R8: After reset, rd_valid stays low until MID_MARK symbols have been stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Write symbol present |
| wr_ctrl | input | 1 | Control flag of write symbol |
| wr_data | input | 8 | Write symbol value |
| sync_ok | input | 1 | Lane sync status, write domain |
| wr_deleted | output | 1 | High one write cycle when an I2 pair is dropped |
| rd_clk | input | 1 | Local reference clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | Read symbol present |
| rd_ctrl | output | 1 | Control flag of read symbol |
| rd_data | output | 8 | Read symbol value |
| rd_inserted | output | 1 | High on both symbols of a replayed I2 pair |

## Verification
The assertions assume that the upstream source leaves enough I2 pairs in its inter-packet gaps for the write side to drain before the store fills. They also assume that the write stream is continuous inside each scenario, so that the symbol staged for pairing is always the one written just before. The stimulus sends idle runs of several I2 pairs between short packets, keeps wr_valid high throughout each scenario, and limits the clock offset to 2 % so that correction always has idle pairs to act on. The C1-only scenario runs only briefly, because a fast reader with nothing to replay may underflow, and that is allowed as gaps in rd_valid.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } sym_t;

    localparam logic [7:0] COMMA_VAL = 8'hBC;
    localparam logic [7:0] IDLE2_VAL = 8'h50;

    typedef enum logic [1:0] {RD_NORM, RD_REP_K, RD_REP_D} rd_state_t;

    function automatic logic is_comma(sym_t s);
        return s.ctrl && (s.data == COMMA_VAL);
    endfunction

    function automatic logic is_idle2(sym_t s);
        return !s.ctrl && (s.data == IDLE2_VAL);
    endfunction

endpackage

// File: rtl/rmf_sync.sv
module rmf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rmf_wr.sv
module rmf_wr
    import rmf_pkg::*;
#(
    parameter int AW      = 4,
    parameter int HI_MARK = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  sym_t          in_sym,
    input  logic          sync_in,
    input  logic [AW:0]   rptr_gray_s,
    input  logic [AW-1:0] rd_addr,
    output sym_t          rd_sym,
    output logic [AW:0]   wptr_gray,
    output logic          deleted
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    sym_t        mem [DEPTH];
    sym_t        staged;
    logic        staged_v;
    logic [AW:0] wptr, rptr_b, wfill;
    logic        drop, wr_en;

    always_comb begin
        rptr_b = '0;
        for (int i = AW; i >= 0; i--)
            rptr_b[i] = (i == AW) ? rptr_gray_s[i] : (rptr_b[i+1] ^ rptr_gray_s[i]);
    end

    assign wfill  = wptr - rptr_b;
    assign drop   = in_valid && sync_in && staged_v && is_comma(staged) &&
                    is_idle2(in_sym) && (wfill > PW'(HI_MARK));
    assign wr_en  = in_valid && staged_v && !drop;
    assign rd_sym = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr[AW-1:0]] <= staged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged    <= '0;
            staged_v  <= 1'b0;
            wptr      <= '0;
            wptr_gray <= '0;
            deleted   <= 1'b0;
        end else begin
            deleted <= drop;
            if (wr_en) begin
                wptr      <= wptr + 1'b1;
                wptr_gray <= (wptr + 1'b1) ^ ((wptr + 1'b1) >> 1);
            end
            if (in_valid) begin
                if (drop) staged_v <= 1'b0;
                else begin
                    staged   <= in_sym;
                    staged_v <= 1'b1;
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wfill < PW'(DEPTH))); // R7
    AST_DEL_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
        deleted |-> $past(sync_in)); // R2
    AST_DEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        deleted |=> !deleted); // R3
endmodule

// File: rtl/rmf_rd.sv
module rmf_rd
    import rmf_pkg::*;
#(
    parameter int AW       = 4,
    parameter int LO_MARK  = 4,
    parameter int MID_MARK = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW:0]   wptr_gray_s,
    input  logic          sync_s,
    input  sym_t          rd_sym,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rptr_gray,
    output logic          out_valid,
    output sym_t          out_sym,
    output logic          out_ins
);
    localparam int PW = AW + 1;

    logic [AW:0] rptr, wptr_b, rfill;
    logic        primed, last_k;
    rd_state_t   st;

    always_comb begin
        wptr_b = '0;
        for (int i = AW; i >= 0; i--)
            wptr_b[i] = (i == AW) ? wptr_gray_s[i] : (wptr_b[i+1] ^ wptr_gray_s[i]);
    end

    assign rfill   = wptr_b - rptr;
    assign rd_addr = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr      <= '0;
            rptr_gray <= '0;
            primed    <= 1'b0;
            last_k    <= 1'b0;
            st        <= RD_NORM;
            out_valid <= 1'b0;
            out_ins   <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_ins   <= 1'b0;
            if (!primed) begin
                primed <= (rfill >= PW'(MID_MARK));
            end else begin
                case (st)
                    RD_REP_K: begin
                        out_sym   <= '{ctrl: 1'b1, data: COMMA_VAL};
                        out_valid <= 1'b1;
                        out_ins   <= 1'b1;
                        st        <= RD_REP_D;
                    end
                    RD_REP_D: begin
                        out_sym   <= '{ctrl: 1'b0, data: IDLE2_VAL};
                        out_valid <= 1'b1;
                        out_ins   <= 1'b1;
                        last_k    <= 1'b0;
                        st        <= RD_NORM;
                    end
                    default: begin
                        if (rfill != '0) begin
                            out_sym   <= rd_sym;
                            out_valid <= 1'b1;
                            rptr      <= rptr + 1'b1;
                            rptr_gray <= (rptr + 1'b1) ^ ((rptr + 1'b1) >> 1);
                            last_k    <= is_comma(rd_sym);
                            if (last_k && is_idle2(rd_sym) && sync_s &&
                                (rfill <= PW'(LO_MARK)))
                                st <= RD_REP_K;
                        end
                    end
                endcase
            end
        end
    end

    AST_INS_PAIR: assert property (@(posedge clk) disable iff (rst)
        (out_ins && out_sym.ctrl) |=> (out_ins && !out_sym.ctrl && out_sym.data == IDLE2_VAL)); // R4
    AST_INS_AFTER_PRIME: assert property (@(posedge clk) disable iff (rst)
        out_ins |-> primed); // R8
    AST_INS_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_ins |-> out_valid); // R5
endmodule

// File: rtl/rmf_top.sv
module rmf_top
    import rmf_pkg::*;
#(
    parameter int AW       = 4,
    parameter int HI_MARK  = 12,
    parameter int LO_MARK  = 4,
    parameter int MID_MARK = 8
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       wr_valid,
    input  logic       wr_ctrl,
    input  logic [7:0] wr_data,
    input  logic       sync_ok,
    output logic       wr_deleted,
    input  logic       rd_clk,
    input  logic       rd_rst,
    output logic       rd_valid,
    output logic       rd_ctrl,
    output logic [7:0] rd_data,
    output logic       rd_inserted
);
    logic [AW:0]   wg, wg_s, rg, rg_s;
    logic [AW-1:0] raddr;
    logic          sync_r;
    sym_t          mem_sym, out_sym;

    rmf_wr #(.AW(AW), .HI_MARK(HI_MARK)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid),
        .in_sym('{ctrl: wr_ctrl, data: wr_data}), .sync_in(sync_ok),
        .rptr_gray_s(rg_s), .rd_addr(raddr), .rd_sym(mem_sym),
        .wptr_gray(wg), .deleted(wr_deleted)
    );

    rmf_sync #(.W(AW+1)) u_sync_w2r (.clk(rd_clk), .rst(rd_rst), .d(wg), .q(wg_s));
    rmf_sync #(.W(1))    u_sync_lk  (.clk(rd_clk), .rst(rd_rst), .d(sync_ok), .q(sync_r));
    rmf_sync #(.W(AW+1)) u_sync_r2w (.clk(wr_clk), .rst(wr_rst), .d(rg), .q(rg_s));

    rmf_rd #(.AW(AW), .LO_MARK(LO_MARK), .MID_MARK(MID_MARK)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .wptr_gray_s(wg_s), .sync_s(sync_r),
        .rd_sym(mem_sym), .rd_addr(raddr), .rptr_gray(rg),
        .out_valid(rd_valid), .out_sym(out_sym), .out_ins(rd_inserted)
    );

    assign rd_ctrl = out_sym.ctrl;
    assign rd_data = out_sym.data;
endmodule

// File: tb/rmf_top_tb.sv
`timescale 1ns/1ps
module rmf_top_tb;
    logic       wr_clk = 0, rd_clk = 0;
    logic       wr_rst = 1, rd_rst = 1;
    logic       wr_valid = 0, wr_ctrl = 0, sync_ok = 0;
    logic [7:0] wr_data = 0;
    logic       wr_deleted, rd_valid, rd_ctrl, rd_inserted;
    logic [7:0] rd_data;
    real        rd_half = 2.5;

    int checks = 0, fails = 0;
    int del_sets = 0, ins_sets = 0, ins_phase = 0;
    logic [8:0] expq [$];
    logic [8:0] obsq [$];

    rmf_top u_dut (.*);

    always #2.5 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // read-side collector: replayed symbols are checked and kept out of the stream
    always @(negedge rd_clk) begin
        if (!rd_rst && rd_valid) begin
            if (rd_inserted) begin
                if (ins_phase == 0) begin
                    chk(rd_ctrl && rd_data == 8'hBC, "R4", "replayed first symbol", {rd_ctrl, rd_data}, 9'h1BC);
                    chk(obsq.size() >= 2 && obsq[$-1] == 9'h1BC && obsq[$] == 9'h050,
                        "R4", "replay follows genuine I2", obsq.size(), 2);
                    ins_sets++;
                    ins_phase = 1;
                end else begin
                    chk(!rd_ctrl && rd_data == 8'h50, "R4", "replayed second symbol", {rd_ctrl, rd_data}, 9'h050);
                    ins_phase = 0;
                end
            end else obsq.push_back({rd_ctrl, rd_data});
        end
    end

    task automatic send(input logic c, input logic [7:0] d);
        @(negedge wr_clk);
        if (wr_deleted) begin
            chk(expq.size() >= 2 && expq[$-1] == 9'h1BC && expq[$] == 9'h050,
                "R3", "dropped pair is I2", expq.size() >= 1 ? int'(expq[$]) : 0, 9'h050);
            void'(expq.pop_back());
            void'(expq.pop_back());
            del_sets++;
        end
        wr_valid = 1; wr_ctrl = c; wr_data = d;
        expq.push_back({c, d});
    endtask

    task automatic send_i2();  send(1, 8'hBC); send(0, 8'h50); endtask
    task automatic send_c1();  send(1, 8'hBC); send(0, 8'hB5); endtask
    task automatic send_pkt(input int len, input int seed);
        for (int i = 0; i < len; i++) send(0, 8'((seed * 7 + i * 13) ^ (i == 3 ? 8'h50 : 8'h00)));
    endtask

    task automatic traffic(input int frames, input bit c1_only);
        for (int f = 0; f < frames; f++) begin
            for (int k = 0; k < 6; k++) if (c1_only) send_c1(); else send_i2();
            if (!c1_only) begin send_c1(); send_pkt(20, f); end
        end
    endtask

    task automatic do_reset(input real half);
        wr_valid = 0; sync_ok = 0;
        wr_rst = 1; rd_rst = 1;
        rd_half = half;
        repeat (6) @(negedge wr_clk);
        expq.delete(); obsq.delete();
        del_sets = 0; ins_sets = 0; ins_phase = 0;
        @(negedge rd_clk) rd_rst = 0;
        @(negedge wr_clk) wr_rst = 0;
    endtask

    task automatic compare(input string req);
        int n, bad;
        repeat (60) @(negedge rd_clk);
        n = obsq.size() < expq.size() ? obsq.size() : expq.size();
        bad = 0;
        for (int i = 0; i < n; i++) if (obsq[i] !== expq[i]) bad++;
        chk(bad == 0, req, "symbol mismatches", bad, 0);
        chk(obsq.size() + 24 >= expq.size(), req, "symbols delivered", obsq.size(), expq.size());
    endtask

    task automatic t_reset();
        do_reset(2.5);
        @(negedge wr_clk);
        chk(!rd_valid && !rd_inserted && !wr_deleted, "R1", "outputs after reset",
            {rd_valid, rd_inserted, wr_deleted}, 0);
    endtask

    task automatic t_prime();
        bit seen = 0;
        do_reset(2.5);
        send_i2(); send(1, 8'hBC); send(0, 8'h01);
        @(negedge wr_clk) wr_valid = 0;
        repeat (20) begin @(negedge rd_clk); seen |= rd_valid; end
        chk(!seen, "R8", "rd_valid before nominal fill", seen, 0);
    endtask

    task automatic t_nosync();
        do_reset(2.5);
        traffic(12, 0);
        @(negedge wr_clk) wr_valid = 0;
        compare("R2");
        chk(del_sets == 0 && ins_sets == 0, "R2", "corrections without sync", del_sets + ins_sets, 0);
    endtask

    task automatic t_slow();
        do_reset(2.55);
        sync_ok = 1;
        traffic(60, 0);
        chk(del_sets > 0, "R3", "pairs dropped with slow reader", del_sets, 1);
        chk(ins_sets == 0, "R5", "no replay with slow reader", ins_sets, 0);
        compare("R6");
    endtask

    task automatic t_fast();
        do_reset(2.45);
        sync_ok = 1;
        traffic(60, 0);
        chk(ins_sets > 0, "R4", "pairs replayed with fast reader", ins_sets, 1);
        chk(del_sets == 0, "R7", "no drop with fast reader", del_sets, 0);
        compare("R7");
    endtask

    task automatic t_c1_only();
        do_reset(2.45);
        sync_ok = 1;
        traffic(4, 1);
        chk(ins_sets == 0, "R5", "no replay of C1 pairs", ins_sets, 0);
        compare("R5");
    endtask

    initial begin
        t_reset();
        t_prime();
        t_nosync();
        t_slow();
        t_fast();
        t_c1_only();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2ms;
        chk(0, "WDOG", "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule